// File: doc/BRIEF.md
# Store Queue with Deferred Writeback

This block holds stores in program order in a circular buffer of fixed depth. It is built around three positions: the oldest live entry (head), the next entry to offer to the data cache (writeback pointer), and the next free slot (tail). A store gets a slot when it is allocated, and it records the load-queue tail it saw at that moment. It learns its size and kind when it executes. It becomes eligible to write back when a commit covers its sequence number. A non-speculative store becomes eligible as soon as it executes.

The writeback pointer offers eligible stores to one data-cache port, in order and at most one per cycle. A hit finishes the store on the spot. A miss leaves the store outstanding, and the writeback pointer still moves on to the next store. A later completion tagged with the entry index finishes the missed store, and these completions may arrive in any order. The head retires only a run of consecutive finished entries. A squash trims younger stores from the tail. One stalled load can be registered against a store's sequence number, and that load is released by a replay pulse when the store finishes.

Top module: `store_wb_queue`

## Requirements
- R1: After reset the queue is empty: count 0, head and tail at index 0, full low, no cache request, no replay pulse and no error pulse.
- R2: Each accepted allocation takes the tail index, and indices wrap modulo the depth (8 by default). When count equals the depth, full is high and an allocation is ignored: the tail and the count stay unchanged.
- R3: A commit walks from the head and marks as eligible each store whose sequence number is at or below the commit number. It stops at the first younger store. A store is offered to the cache only when it is both executed and eligible.
- R4: A store executed with the non-speculative flag set is eligible without a commit.
- R5: Requests leave in allocation order, at most one per cycle, with reqIdx and reqSize naming the entry. While cacheBlocked is high the same request is held and nothing advances.
- R6: An eligible store of size zero, or one flagged as a prefetch, finishes without raising reqValid.
- R7: A request that is accepted with cacheHit high finishes the store. The head moves past it at that same clock edge if it is the oldest. With cacheHit low the store stays live until missDoneValid arrives with its index, and the next store can be requested in the meantime.
- R8: The head moves only over consecutive finished entries. A younger store that finishes first keeps its slot until every older store has finished, and then all of them retire together.
- R9: When a store finishes whose sequence number equals the registered stalling store number, replayValid pulses for one cycle, one edge later, carrying the registered load index. The stall is then cleared.
- R10: A squash removes every store younger than the squash number, walking back from the tail. The tail and the count drop by that many, and those slots are reused by later allocations.
- R11: A tagged completion naming an entry that is not live and outstanding changes nothing and raises badCompletion for one cycle.
- R12: headLqTail shows the load-queue tail recorded by the oldest live store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a store at the tail |
| allocSeq | input | 16 | Sequence number of the new store |
| allocLqTail | input | 5 | Load-queue tail at allocation |
| execValid | input | 1 | Store execution result is valid |
| execIdx | input | 3 | Entry that executed |
| execSize | input | 4 | Access size in bytes (0 = no access) |
| execNonSpec | input | 1 | Store is non-speculative |
| execPrefetch | input | 1 | Store is a prefetch hint |
| commitValid | input | 1 | Commit strobe |
| commitSeq | input | 16 | Youngest committed sequence number |
| squashValid | input | 1 | Squash strobe |
| squashSeq | input | 16 | Stores younger than this are removed |
| stallSet | input | 1 | Register a stalled load |
| stallStoreSeq | input | 16 | Store the load waits on |
| stallLoadIdx | input | 5 | Load-queue index of the stalled load |
| cacheBlocked | input | 1 | Cache cannot take a request this cycle |
| cacheHit | input | 1 | Accepted request hit |
| missDoneValid | input | 1 | Tagged miss completion |
| missDoneIdx | input | 3 | Entry index of the completion |
| reqValid | output | 1 | Write request to the cache |
| reqIdx | output | 3 | Entry index of the request |
| reqSize | output | 4 | Size of the request |
| headIdx | output | 3 | Oldest live entry |
| tailIdx | output | 3 | Next slot to allocate |
| count | output | 4 | Live entries |
| full | output | 1 | No free slot |
| headLqTail | output | 5 | Load-queue tail recorded by the head store |
| replayValid | output | 1 | Stalled load may replay |
| replayLoadIdx | output | 5 | Index of that load |
| badCompletion | output | 1 | Completion for a non-outstanding entry |

## Verification
The hardest situation to reach is a set of misses that are in flight together and whose completions arrive youngest first. Only that shows the head holding still while later entries are already finished, and then jumping over the whole run at one edge. The bench gets there by committing four executed stores while the cache is blocked. It holds the first request to show the stall, then lets the requests drain as misses, and returns completions in the order middle, second, first, last. Wrap-around is covered by arranging for the later scenarios to allocate across the end of the index range.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_DEPTH = 8;
  localparam int SEQ_W    = 16;
  localparam int SIZE_W   = 4;
  localparam int LQ_W     = 5;
  localparam int IDX_W    = $clog2(SQ_DEPTH);
  localparam int CNT_W    = $clog2(SQ_DEPTH + 1);

  typedef struct packed {
    logic                alloc;
    logic [IDX_W-1:0]    allocIdx;
    logic [SQ_DEPTH-1:0] markWb;
    logic [SQ_DEPTH-1:0] issue;
    logic [SQ_DEPTH-1:0] complete;
    logic [SQ_DEPTH-1:0] drop;
  } sqStrobes_t;
endpackage

// File: rtl/sq_entries.sv
module sq_entries
  import sq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  sqStrobes_t         strobes,
  input  logic [SEQ_W-1:0]   allocSeq,
  input  logic [LQ_W-1:0]    allocLqTail,
  input  logic               execValid,
  input  logic [IDX_W-1:0]   execIdx,
  input  logic [SIZE_W-1:0]  execSize,
  input  logic               execNonSpec,
  input  logic               execPrefetch,
  output logic [SQ_DEPTH-1:0] validVec,
  output logic [SQ_DEPTH-1:0] execVec,
  output logic [SQ_DEPTH-1:0] canWbVec,
  output logic [SQ_DEPTH-1:0] issuedVec,
  output logic [SQ_DEPTH-1:0] doneVec,
  output logic [SQ_DEPTH-1:0] pfVec,
  output logic [SEQ_W-1:0]   seqArr  [SQ_DEPTH],
  output logic [LQ_W-1:0]    lqArr   [SQ_DEPTH],
  output logic [SIZE_W-1:0]  sizeArr [SQ_DEPTH]
);
  for (genvar g = 0; g < SQ_DEPTH; g++) begin : gEntry
    logic allocHere, execHere;
    assign allocHere = strobes.alloc && (strobes.allocIdx == IDX_W'(g));
    assign execHere  = execValid && (execIdx == IDX_W'(g)) && validVec[g];

    always_ff @(posedge clk) begin
      if (!rstN || strobes.drop[g]) begin
        validVec[g]  <= 1'b0;
        execVec[g]   <= 1'b0;
        canWbVec[g]  <= 1'b0;
        issuedVec[g] <= 1'b0;
        doneVec[g]   <= 1'b0;
        pfVec[g]     <= 1'b0;
        if (!rstN) begin
          seqArr[g]  <= '0;
          lqArr[g]   <= '0;
          sizeArr[g] <= '0;
        end
      end else if (allocHere) begin
        validVec[g]  <= 1'b1;
        execVec[g]   <= 1'b0;
        canWbVec[g]  <= 1'b0;
        issuedVec[g] <= 1'b0;
        doneVec[g]   <= 1'b0;
        pfVec[g]     <= 1'b0;
        seqArr[g]    <= allocSeq;
        lqArr[g]     <= allocLqTail;
        sizeArr[g]   <= '0;
      end else begin
        if (execHere) begin
          execVec[g] <= 1'b1;
          sizeArr[g] <= execSize;
          pfVec[g]   <= execPrefetch;
        end
        if ((execHere && execNonSpec) || strobes.markWb[g]) canWbVec[g] <= 1'b1;
        if (strobes.issue[g])    issuedVec[g] <= 1'b1;
        if (strobes.complete[g]) doneVec[g]   <= 1'b1;
      end
    end
  end

  // R3
  mark_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.markWb & ~validVec) == '0);
  // R3
  issue_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue & ~(execVec & canWbVec)) == '0);
  // R7
  complete_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.complete & ~validVec) == '0);
  // R8
  drop_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drop & ~validVec) == '0);
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic               commitValid,
  input  logic [SEQ_W-1:0]   commitSeq,
  input  logic               squashValid,
  input  logic [SEQ_W-1:0]   squashSeq,
  input  logic               stallSet,
  input  logic [SEQ_W-1:0]   stallStoreSeq,
  input  logic [LQ_W-1:0]    stallLoadIdx,
  input  logic               cacheBlocked,
  input  logic               cacheHit,
  input  logic               missDoneValid,
  input  logic [IDX_W-1:0]   missDoneIdx,
  input  logic [SQ_DEPTH-1:0] validVec,
  input  logic [SQ_DEPTH-1:0] execVec,
  input  logic [SQ_DEPTH-1:0] canWbVec,
  input  logic [SQ_DEPTH-1:0] issuedVec,
  input  logic [SQ_DEPTH-1:0] doneVec,
  input  logic [SQ_DEPTH-1:0] pfVec,
  input  logic [SEQ_W-1:0]   seqArr  [SQ_DEPTH],
  input  logic [SIZE_W-1:0]  sizeArr [SQ_DEPTH],
  output sqStrobes_t         strobes,
  output logic               reqValid,
  output logic [IDX_W-1:0]   reqIdx,
  output logic [SIZE_W-1:0]  reqSize,
  output logic [IDX_W-1:0]   headIdx,
  output logic [IDX_W-1:0]   tailIdx,
  output logic [CNT_W-1:0]   count,
  output logic               full,
  output logic               replayValid,
  output logic [LQ_W-1:0]    replayLoadIdx,
  output logic               badCompletion
);
  logic [IDX_W-1:0]    wbPtr;
  logic                stallActive;
  logic [SEQ_W-1:0]    stallSeq;
  logic [LQ_W-1:0]     stallLoad;
  logic                allocOk, wbAdv, missOk, stallHit, stallGone;
  logic [SQ_DEPTH-1:0] sqMask, compNext;
  int                  retN, sqN;

  function automatic int wrapIdx(input int base, input int k);
    return (base + k + SQ_DEPTH) % SQ_DEPTH;
  endfunction

  assign full    = (count == CNT_W'(SQ_DEPTH));
  assign allocOk = allocValid && !full && !squashValid;
  assign reqIdx  = wbPtr;
  assign reqSize = sizeArr[wbPtr];
  assign missOk  = validVec[missDoneIdx] && issuedVec[missDoneIdx] && !doneVec[missDoneIdx];

  always_comb begin
    logic stopC, stopS, stopR;
    strobes = '0;
    strobes.alloc    = allocOk;
    strobes.allocIdx = tailIdx;
    // commit walk from head
    stopC = 1'b0;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      int e;
      e = wrapIdx(int'(headIdx), k);
      if (commitValid && !squashValid && !stopC && k < int'(count) && !canWbVec[e]) begin
        if (seqArr[e] > commitSeq) stopC = 1'b1;
        else strobes.markWb[e] = 1'b1;
      end
    end
    // squash walk from tail
    sqMask = '0; sqN = 0; stopS = 1'b0;
    for (int k = 1; k <= SQ_DEPTH; k++) begin
      int e;
      e = wrapIdx(int'(tailIdx), -k);
      if (squashValid && !stopS && k <= int'(count)) begin
        if (seqArr[e] > squashSeq) begin
          sqMask[e] = 1'b1;
          sqN = sqN + 1;
        end else stopS = 1'b1;
      end
    end
    // writeback stage
    reqValid = 1'b0; wbAdv = 1'b0;
    if (validVec[wbPtr] && execVec[wbPtr] && canWbVec[wbPtr] &&
        !issuedVec[wbPtr] && !doneVec[wbPtr]) begin
      if (sizeArr[wbPtr] == '0 || pfVec[wbPtr]) begin
        strobes.complete[wbPtr] = 1'b1;
        wbAdv = 1'b1;
      end else begin
        reqValid = 1'b1;
        if (!cacheBlocked) begin
          wbAdv = 1'b1;
          if (cacheHit) strobes.complete[wbPtr] = 1'b1;
          else          strobes.issue[wbPtr]    = 1'b1;
        end
      end
    end
    if (missDoneValid && missOk) strobes.complete[missDoneIdx] = 1'b1;
    // retire run of finished entries
    compNext = doneVec | strobes.complete;
    retN = 0; stopR = 1'b0;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      int e;
      e = wrapIdx(int'(headIdx), k);
      if (!stopR && k < int'(count) && compNext[e]) begin
        strobes.drop[e] = 1'b1;
        retN = retN + 1;
      end else stopR = 1'b1;
    end
    strobes.drop = strobes.drop | sqMask;
    // stall release
    stallHit = 1'b0; stallGone = 1'b0;
    for (int i = 0; i < SQ_DEPTH; i++) begin
      if (stallActive && strobes.complete[i] && seqArr[i] == stallSeq) stallHit = 1'b1;
      if (stallActive && sqMask[i] && seqArr[i] == stallSeq) stallGone = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0; tailIdx <= '0; wbPtr <= '0; count <= '0;
      stallActive <= 1'b0; stallSeq <= '0; stallLoad <= '0;
      replayValid <= 1'b0; replayLoadIdx <= '0; badCompletion <= 1'b0;
    end else begin
      headIdx <= IDX_W'(wrapIdx(int'(headIdx), retN));
      if (squashValid)  tailIdx <= IDX_W'(wrapIdx(int'(tailIdx), -sqN));
      else if (allocOk) tailIdx <= IDX_W'(wrapIdx(int'(tailIdx), 1));
      if (wbAdv) wbPtr <= IDX_W'(wrapIdx(int'(wbPtr), 1));
      count <= CNT_W'(int'(count) + int'(allocOk) - retN - sqN);
      badCompletion <= missDoneValid && !missOk;
      replayValid   <= stallHit;
      if (stallHit) replayLoadIdx <= stallLoad;
      if (stallSet) begin
        stallActive <= 1'b1;
        stallSeq    <= stallStoreSeq;
        stallLoad   <= stallLoadIdx;
      end else if (stallHit || stallGone) stallActive <= 1'b0;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(SQ_DEPTH));
  // R2
  tail_hold_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && !squashValid) |=> $stable(tailIdx));
  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cacheBlocked && !squashValid) |=> $stable(wbPtr));
endmodule

// File: rtl/store_wb_queue.sv
module store_wb_queue
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic [LQ_W-1:0]   allocLqTail,
  input  logic              execValid,
  input  logic [IDX_W-1:0]  execIdx,
  input  logic [SIZE_W-1:0] execSize,
  input  logic              execNonSpec,
  input  logic              execPrefetch,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              stallSet,
  input  logic [SEQ_W-1:0]  stallStoreSeq,
  input  logic [LQ_W-1:0]   stallLoadIdx,
  input  logic              cacheBlocked,
  input  logic              cacheHit,
  input  logic              missDoneValid,
  input  logic [IDX_W-1:0]  missDoneIdx,
  output logic              reqValid,
  output logic [IDX_W-1:0]  reqIdx,
  output logic [SIZE_W-1:0] reqSize,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic [LQ_W-1:0]   headLqTail,
  output logic              replayValid,
  output logic [LQ_W-1:0]   replayLoadIdx,
  output logic              badCompletion
);
  sqStrobes_t          strobes;
  logic [SQ_DEPTH-1:0] validVec, execVec, canWbVec, issuedVec, doneVec, pfVec;
  logic [SEQ_W-1:0]    seqArr  [SQ_DEPTH];
  logic [LQ_W-1:0]     lqArr   [SQ_DEPTH];
  logic [SIZE_W-1:0]   sizeArr [SQ_DEPTH];

  assign headLqTail = lqArr[headIdx];

  sq_entries u_entries (
    .clk, .rstN, .strobes, .allocSeq, .allocLqTail,
    .execValid, .execIdx, .execSize, .execNonSpec, .execPrefetch,
    .validVec, .execVec, .canWbVec, .issuedVec, .doneVec, .pfVec,
    .seqArr, .lqArr, .sizeArr
  );

  sq_ctrl u_ctrl (
    .clk, .rstN, .allocValid, .commitValid, .commitSeq, .squashValid, .squashSeq,
    .stallSet, .stallStoreSeq, .stallLoadIdx, .cacheBlocked, .cacheHit,
    .missDoneValid, .missDoneIdx,
    .validVec, .execVec, .canWbVec, .issuedVec, .doneVec, .pfVec,
    .seqArr, .sizeArr, .strobes,
    .reqValid, .reqIdx, .reqSize, .headIdx, .tailIdx, .count, .full,
    .replayValid, .replayLoadIdx, .badCompletion
  );
endmodule

// File: tb/store_wb_queue_tb.sv
module store_wb_queue_tb;
  import sq_pkg::*;
  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, execValid = 0, execNonSpec = 0, execPrefetch = 0;
  logic commitValid = 0, squashValid = 0, stallSet = 0;
  logic cacheBlocked = 0, cacheHit = 1, missDoneValid = 0;
  logic [SEQ_W-1:0] allocSeq = 0, commitSeq = 0, squashSeq = 0, stallStoreSeq = 0;
  logic [LQ_W-1:0] allocLqTail = 0, stallLoadIdx = 0;
  logic [IDX_W-1:0] execIdx = 0, missDoneIdx = 0;
  logic [SIZE_W-1:0] execSize = 0;
  logic reqValid, full, replayValid, badCompletion;
  logic [IDX_W-1:0] reqIdx, headIdx, tailIdx;
  logic [SIZE_W-1:0] reqSize;
  logic [CNT_W-1:0] count;
  logic [LQ_W-1:0] headLqTail, replayLoadIdx;
  int nChecks = 0, nErrors = 0;

  always #10 clk = ~clk;

  store_wb_queue u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    allocValid = 0; execValid = 0; commitValid = 0; squashValid = 0;
    stallSet = 0; missDoneValid = 0; execNonSpec = 0; execPrefetch = 0;
    #1;
  endtask

  task automatic alloc(input int seq, input int lq, input int expIdx);
    allocValid = 1; allocSeq = SEQ_W'(seq); allocLqTail = LQ_W'(lq);
    chk("R2 alloc index", int'(tailIdx), expIdx);
    cyc();
  endtask

  task automatic exec(input int idx, input int size, input bit ns, input bit pf);
    execValid = 1; execIdx = IDX_W'(idx); execSize = SIZE_W'(size);
    execNonSpec = ns; execPrefetch = pf;
    cyc();
  endtask

  task automatic commit(input int seq);
    commitValid = 1; commitSeq = SEQ_W'(seq);
    cyc();
  endtask

  task automatic tResetState();
    chk("R1 count", int'(count), 0);
    chk("R1 head", int'(headIdx), 0);
    chk("R1 tail", int'(tailIdx), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 req", int'(reqValid), 0);
    chk("R1 replay", int'(replayValid), 0);
    chk("R1 err", int'(badCompletion), 0);
  endtask

  task automatic tInOrderHits();
    alloc(10, 3, 0); alloc(11, 4, 1); alloc(12, 5, 2);
    chk("R2 count", int'(count), 3);
    chk("R12 head lq tail", int'(headLqTail), 3);
    exec(0, 4, 0, 0); exec(1, 4, 0, 0); exec(2, 4, 0, 0);
    chk("R3 no req before commit", int'(reqValid), 0);
    commit(11);
    chk("R5 first req", int'(reqValid), 1);
    chk("R5 first idx", int'(reqIdx), 0);
    chk("R5 req size", int'(reqSize), 4);
    cyc();
    chk("R7 head after hit", int'(headIdx), 1);
    chk("R5 second idx", int'(reqIdx), 1);
    cyc();
    chk("R3 younger not eligible", int'(reqValid), 0);
    chk("R7 head", int'(headIdx), 2);
    commit(12);
    chk("R3 req after commit", int'(reqIdx), 2);
    cyc();
    chk("R7 empty", int'(count), 0);
    chk("R7 head wraps on", int'(headIdx), 3);
  endtask

  task automatic tMissesOutOfOrder();
    alloc(20, 0, 3); alloc(21, 0, 4); alloc(22, 0, 5); alloc(23, 0, 6);
    for (int i = 3; i < 7; i++) exec(i, 2, 0, 0);
    cacheBlocked = 1;
    commit(23);
    chk("R5 blocked req", int'(reqIdx), 3);
    cyc();
    chk("R5 blocked hold valid", int'(reqValid), 1);
    chk("R5 blocked hold idx", int'(reqIdx), 3);
    cacheBlocked = 0; cacheHit = 0;
    for (int i = 3; i < 7; i++) begin
      chk("R7 miss issue order", int'(reqIdx), i);
      cyc();
    end
    chk("R7 all issued", int'(reqValid), 0);
    chk("R7 misses live", int'(count), 4);
    missDoneValid = 1; missDoneIdx = 3'd5; cyc();
    chk("R8 head waits", int'(headIdx), 3);
    missDoneValid = 1; missDoneIdx = 3'd4; cyc();
    chk("R8 count waits", int'(count), 4);
    missDoneValid = 1; missDoneIdx = 3'd3; cyc();
    chk("R8 run retired head", int'(headIdx), 6);
    chk("R8 run retired count", int'(count), 1);
    missDoneValid = 1; missDoneIdx = 3'd6; cyc();
    chk("R7 miss done", int'(count), 0);
    missDoneValid = 1; missDoneIdx = 3'd5; cyc();
    chk("R11 error pulse", int'(badCompletion), 1);
    chk("R11 state unchanged", int'(count), 0);
    cyc();
    chk("R11 error one cycle", int'(badCompletion), 0);
    cacheHit = 1;
  endtask

  task automatic tSkipAndNonSpec();
    alloc(30, 1, 7); alloc(31, 1, 0); alloc(32, 1, 1);
    exec(7, 0, 1, 0);
    chk("R6 zero size no req", int'(reqValid), 0);
    cyc();
    chk("R6 zero size retired", int'(headIdx), 0);
    exec(0, 4, 1, 1);
    chk("R6 prefetch no req", int'(reqValid), 0);
    cyc();
    chk("R6 prefetch retired", int'(headIdx), 1);
    exec(1, 4, 1, 0);
    chk("R4 nonspec req", int'(reqValid), 1);
    chk("R4 nonspec idx", int'(reqIdx), 1);
    cyc();
    chk("R4 retired", int'(count), 0);
  endtask

  task automatic tReplay();
    alloc(40, 7, 2);
    chk("R12 recorded lq tail", int'(headLqTail), 7);
    stallSet = 1; stallStoreSeq = 16'd40; stallLoadIdx = 5'd9;
    exec(2, 4, 0, 0);
    chk("R9 no early replay", int'(replayValid), 0);
    commit(40);
    chk("R9 store requested", int'(reqIdx), 2);
    cyc();
    chk("R9 replay pulse", int'(replayValid), 1);
    chk("R9 replay load idx", int'(replayLoadIdx), 9);
    cyc();
    chk("R9 pulse ends", int'(replayValid), 0);
  endtask

  task automatic tSquash();
    alloc(50, 0, 3); alloc(51, 0, 4); alloc(52, 0, 5); alloc(53, 0, 6);
    squashValid = 1; squashSeq = 16'd51; cyc();
    chk("R10 tail back", int'(tailIdx), 5);
    chk("R10 count", int'(count), 2);
    alloc(60, 0, 5);
    exec(3, 4, 0, 0); exec(4, 4, 0, 0); exec(5, 4, 0, 0);
    commit(60);
    for (int i = 3; i < 6; i++) begin
      chk("R10 reuse writeback order", int'(reqIdx), i);
      cyc();
    end
    chk("R10 drained", int'(count), 0);
    chk("R10 no stray req", int'(reqValid), 0);
  endtask

  task automatic tFull();
    for (int i = 0; i < SQ_DEPTH; i++) alloc(70 + i, 0, (6 + i) % SQ_DEPTH);
    chk("R2 full", int'(full), 1);
    allocValid = 1; allocSeq = 16'd78; cyc();
    chk("R2 ignored tail", int'(tailIdx), 6);
    chk("R2 ignored count", int'(count), SQ_DEPTH);
    squashValid = 1; squashSeq = 16'd69; cyc();
    chk("R10 squash all", int'(count), 0);
    chk("R10 tail after all", int'(tailIdx), 6);
    chk("R2 not full", int'(full), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; #1;
    tResetState();
    tInOrderHits();
    tMissesOutOfOrder();
    tSkipAndNonSpec();
    tReplay();
    tSquash();
    tFull();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule